// File: doc/BRIEF.md
# Gated Period-Match Timer

A 16-bit timer/counter for a processor subsystem. It advances on one of three clock sources: the internal instruction clock, a resynchronised external clock pin, or the raw external pin used directly. A prescaler of 1, 8, 64 or 256 sits in front of the counter. When the count equals the period register on an advance, the count goes back to zero and the block pulses its interrupt request. In timer mode an optional gate input lets the count accumulate only while the gate is high. A falling gate edge also raises the interrupt request.

Idle and sleep status inputs from the CPU stop the count. The effect depends on the clock source. Both modes clocked by the instruction clock stop in sleep, and they stop in idle when the stop-in-idle bit is set. The unsynchronised counter mode ignores both inputs. Software reaches three registers through a simple write/read port: control, count and period.

Top module: `gt16_timer`

## Requirements
- R1: After reset, control reads 0x0000, count reads 0x0000, period reads 0xFFFF and the interrupt request is low.
- R2: Control bit 15 turns the timer on. With bits 1 and 6 clear, the count rises by one on each prescaled instruction-clock tick. When bit 15 is clear the count holds.
- R3: When an advance happens while the count equals the period, the next count is zero and the interrupt request is high for exactly one cycle, in the cycle after that edge.
- R4: Control bits [5:4] choose the prescale ratio: 0→1, 1→8, 2→64, 3→256. Any write to the control or count register clears the prescaler's partial progress.
- R5: Control bit 13 is stop-in-idle. In timer and synchronous counter modes, the count freezes while the idle input is high and the bit is 1. With the bit at 0 the count keeps running in idle.
- R6: While the sleep input is high, the count freezes in timer mode and in synchronous counter mode.
- R7: Synchronous counter mode (bit 1 = 1, bit 2 = 1) counts each rising edge of the external clock pin once. The pin passes through a two-flop synchroniser first.
- R8: Asynchronous counter mode (bit 1 = 1, bit 2 = 0) counts rising edges of the external pin without the synchroniser. It keeps counting in idle and in sleep, whatever bit 13 holds.
- R9: Gated mode is control bit 6 in timer mode. The count accumulates instruction-clock ticks only while the synchronised gate input is high.
- R10: In gated timer mode, a falling edge of the synchronised gate pulses the interrupt request for one cycle.
- R11: The write select is 0 = control, 1 = count, 2 = period, and the read select uses the same codes. A count write takes effect at the next edge, before any advance in that cycle, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 count, 2 period |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read source, same codes as the write select |
| rd_data_o | output | 16 | Read data, combinational from the registers |
| ext_clk_i | input | 1 | External count clock pin |
| gate_i | input | 1 | Gate pin for accumulation |
| cpu_idle_i | input | 1 | CPU is idle |
| cpu_sleep_i | input | 1 | CPU is asleep |
| irq_o | output | 1 | Interrupt request, one-cycle pulse |

## Verification
The assertions assume that the idle and sleep inputs are steady levels, changed by the CPU away from the clock edge. They also assume that software changes the clock source and prescale ratio only through a control write, which clears the prescaler. The stimulus keeps to these assumptions. Every control change is a full control write. The external clock and gate pins move at least two instruction cycles apart, so each level lasts long enough for the synchroniser to see it. Idle and sleep change only between measurement windows.

// File: rtl/gt16_pkg.sv
package gt16_pkg;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_ASYNC = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;

  localparam int unsigned CTRL_ON_BIT   = 15;
  localparam int unsigned CTRL_SIDL_BIT = 13;
  localparam int unsigned CTRL_GATE_BIT = 6;
  localparam int unsigned CTRL_PS_LSB   = 4;
  localparam int unsigned CTRL_SYNC_BIT = 2;
  localparam int unsigned CTRL_EXT_BIT  = 1;

  function automatic src_e decode_src(input logic ext, input logic sync);
    if (!ext)      return SRC_TIMER;
    else if (sync) return SRC_SYNC;
    else           return SRC_ASYNC;
  endfunction

endpackage

// File: rtl/gt16_tick_src.sv
module gt16_tick_src
  import gt16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic on_i,
  input  logic stop_idle_i,
  input  logic gate_en_i,
  input  logic cpu_idle_i,
  input  logic cpu_sleep_i,
  input  logic ext_clk_i,
  input  logic gate_i,
  output logic tick_o,
  output logic gate_fall_o
);

  // synchroniser stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] ext_sync_q, ext_sync_d;
  logic [SYNC_STAGES:0] gate_sync_q, gate_sync_d;
  logic [1:0]           ext_raw_q, ext_raw_d;

  logic sync_rise, async_rise, gate_lvl, gate_fall, halted, src_tick;

  always_comb begin
    ext_sync_d  = {ext_sync_q[SYNC_STAGES-1:0], ext_clk_i};
    gate_sync_d = {gate_sync_q[SYNC_STAGES-1:0], gate_i};
    ext_raw_d   = {ext_raw_q[0], ext_clk_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync_q  <= '0;
      gate_sync_q <= '0;
      ext_raw_q   <= '0;
    end else begin
      ext_sync_q  <= ext_sync_d;
      gate_sync_q <= gate_sync_d;
      ext_raw_q   <= ext_raw_d;
    end
  end

  always_comb begin
    sync_rise  = ext_sync_q[SYNC_STAGES-1] & ~ext_sync_q[SYNC_STAGES];
    async_rise = ext_raw_q[0] & ~ext_raw_q[1];
    gate_lvl   = gate_sync_q[SYNC_STAGES-1];
    gate_fall  = ~gate_sync_q[SYNC_STAGES-1] & gate_sync_q[SYNC_STAGES];
    // modes on the instruction clock stop in sleep, and in idle on request
    halted     = (src_i != SRC_ASYNC) &&
                 (cpu_sleep_i || (cpu_idle_i && stop_idle_i));
    unique case (src_i)
      SRC_TIMER: src_tick = gate_en_i ? gate_lvl : 1'b1;
      SRC_SYNC:  src_tick = sync_rise;
      default:   src_tick = async_rise;
    endcase
    tick_o      = on_i && !halted && src_tick;
    gate_fall_o = on_i && gate_en_i && (src_i == SRC_TIMER) && gate_fall;
  end

endmodule

// File: rtl/gt16_prescale.sv
module gt16_prescale #(
  parameter int LOG_R1 = 3,
  parameter int LOG_R2 = 6,
  parameter int LOG_R3 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] ratio_i,
  output logic       adv_o
);

  localparam int PS_W = LOG_R3;

  logic [PS_W-1:0] ps_q, ps_d, limit;

  always_comb begin
    unique case (ratio_i)
      2'd0:    limit = '0;
      2'd1:    limit = PS_W'((1 << LOG_R1) - 1);
      2'd2:    limit = PS_W'((1 << LOG_R2) - 1);
      default: limit = PS_W'((1 << LOG_R3) - 1);
    endcase
    adv_o = tick_i && (ps_q == limit);
    if (clr_i)       ps_d = '0;
    else if (adv_o)  ps_d = '0;
    else if (tick_i) ps_d = ps_q + 1'b1;
    else             ps_d = ps_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= '0;
    else         ps_q <= ps_d;
  end

  // R4: partial progress never passes the selected ratio
  assert_ps_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_q <= limit)
    else $error("prescaler beyond ratio");

endmodule

// File: rtl/gt16_count.sv
module gt16_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         adv_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         roll_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    roll_o = adv_i && !wr_i && (cnt_q == period_i);
    if (wr_i)        cnt_d = wr_val_i;
    else if (roll_o) cnt_d = '0;
    else if (adv_i)  cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && cnt_q != period_i) |=> cnt_q == W'($past(cnt_q) + 1'b1))
    else $error("count did not step by one");

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_o |=> cnt_q == '0)
    else $error("count did not return to zero at period");

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_i) |=> $stable(cnt_q))
    else $error("count moved without an advance");

endmodule

// File: rtl/gt16_timer.sv
module gt16_timer
  import gt16_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LOG_R1      = 3,
  parameter int LOG_R2      = 6,
  parameter int LOG_R3      = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  input  logic         ext_clk_i,
  input  logic         gate_i,
  input  logic         cpu_idle_i,
  input  logic         cpu_sleep_i,
  output logic         irq_o
);

  localparam logic [W-1:0] PERIOD_RST = '1;

  logic [W-1:0] ctrl_q, ctrl_d, period_q, period_d, cnt;
  logic         irq_q, irq_d;
  logic         wr_ctrl, wr_cnt, wr_per;
  logic         tick, adv, roll, gate_fall;
  src_e         src;

  always_comb begin
    wr_ctrl  = wr_en_i && (sel_e'(wr_sel_i) == SEL_CTRL);
    wr_cnt   = wr_en_i && (sel_e'(wr_sel_i) == SEL_COUNT);
    wr_per   = wr_en_i && (sel_e'(wr_sel_i) == SEL_PERIOD);
    ctrl_d   = wr_ctrl ? wr_data_i : ctrl_q;
    period_d = wr_per  ? wr_data_i : period_q;
    src      = decode_src(ctrl_q[CTRL_EXT_BIT], ctrl_q[CTRL_SYNC_BIT]);
    irq_d    = roll || gate_fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      irq_q    <= irq_d;
    end
  end

  gt16_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src),
    .on_i        (ctrl_q[CTRL_ON_BIT]),
    .stop_idle_i (ctrl_q[CTRL_SIDL_BIT]),
    .gate_en_i   (ctrl_q[CTRL_GATE_BIT]),
    .cpu_idle_i  (cpu_idle_i),
    .cpu_sleep_i (cpu_sleep_i),
    .ext_clk_i   (ext_clk_i),
    .gate_i      (gate_i),
    .tick_o      (tick),
    .gate_fall_o (gate_fall)
  );

  gt16_prescale #(.LOG_R1(LOG_R1), .LOG_R2(LOG_R2), .LOG_R3(LOG_R3)) u_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_ctrl || wr_cnt),
    .tick_i  (tick),
    .ratio_i (ctrl_q[CTRL_PS_LSB +: 2]),
    .adv_o   (adv)
  );

  gt16_count #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_cnt),
    .wr_val_i (wr_data_i),
    .adv_i    (adv),
    .period_i (period_q),
    .cnt_o    (cnt),
    .roll_o   (roll)
  );

  always_comb begin
    unique case (sel_e'(rd_sel_i))
      SEL_CTRL:   rd_data_o = ctrl_q;
      SEL_COUNT:  rd_data_o = cnt;
      SEL_PERIOD: rd_data_o = period_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  assert_idle_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_SIDL_BIT] && cpu_idle_i && src != SRC_ASYNC && !wr_cnt)
      |=> $stable(cnt))
    else $error("count moved in idle with stop bit set");

  assert_sleep_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_sleep_i && src != SRC_ASYNC && !wr_cnt) |=> $stable(cnt))
    else $error("count moved in sleep");

  assert_gate_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_fall |=> irq_o)
    else $error("gate fall did not raise interrupt");

  assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !roll && !gate_fall) |=> !irq_o)
    else $error("interrupt held beyond one cycle");

endmodule

// File: tb/gt16_timer_tb_top.sv
module gt16_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic [1:0]  rd_sel_i = 2'd1;
  logic [15:0] rd_data_o;
  logic        ext_clk_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        cpu_idle_i = 1'b0;
  logic        cpu_sleep_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gt16_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .ext_clk_i(ext_clk_i), .gate_i(gate_i), .cpu_idle_i(cpu_idle_i),
    .cpu_sleep_i(cpu_sleep_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  ps;
    logic [15:0] period;
    logic [15:0] cycles;
    logic [15:0] exp_cnt;
    logic [15:0] exp_irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 16'hFFFF, 16'd20,  16'd20, 16'd0},
    '{2'd0, 16'd9,    16'd25,  16'd5,  16'd2},
    '{2'd1, 16'hFFFF, 16'd50,  16'd6,  16'd0},
    '{2'd2, 16'hFFFF, 16'd200, 16'd3,  16'd0},
    '{2'd3, 16'hFFFF, 16'd600, 16'd2,  16'd0},
    '{2'd1, 16'd2,    16'd100, 16'd0,  16'd4},
    '{2'd0, 16'd0,    16'd7,   16'd0,  16'd7}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    rd_sel_i = sel;
    #1;
    v = rd_data_o;
    rd_sel_i = 2'd1;
  endtask

  task automatic run(input int n, output int irqs);
    irqs = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (irq_o === 1'b1) irqs++;
    end
  endtask

  task automatic ext_pulses(input int k);
    repeat (k) begin
      @(negedge clk_i); ext_clk_i = 1'b1;
      repeat (2) @(negedge clk_i);
      ext_clk_i = 1'b0;
      @(negedge clk_i);
    end
    repeat (5) @(negedge clk_i);
  endtask

  task automatic setup(input logic [15:0] ctrl, input logic [15:0] per);
    wr(2'd0, 16'h0000);
    wr(2'd2, per);
    wr(2'd1, 16'h0000);
    wr(2'd0, ctrl);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a, b, v;
    int irqs;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 count", v, 16'h0000);
    rd(2'd2, v); chk("R1 period", v, 16'hFFFF);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);

    // vector table: timer mode, ratios and periods
    for (int i = 0; i < 7; i++) begin
      setup(16'h8000 | {10'd0, VECS[i].ps, 4'd0}, VECS[i].period);
      run(int'(VECS[i].cycles), irqs);
      rd(2'd1, v);
      chk($sformatf("R2 R4 vec%0d count", i), v, VECS[i].exp_cnt);
      chk($sformatf("R3 vec%0d irq pulses", i), 16'(irqs), VECS[i].exp_irq);
    end

    // R2 disabled holds
    setup(16'h0000, 16'hFFFF);
    wr(2'd1, 16'd42);
    run(10, irqs);
    rd(2'd1, v); chk("R2 disabled hold", v, 16'd42);

    // R11 count write then continue, period read back
    setup(16'h8000, 16'h1234);
    wr(2'd1, 16'd100);
    run(5, irqs);
    rd(2'd1, v); chk("R11 count write continue", v, 16'd105);
    rd(2'd2, v); chk("R11 period readback", v, 16'h1234);

    // R4 prescaler cleared by count write and by control write
    setup(16'h8010, 16'hFFFF);
    run(5, irqs);
    wr(2'd1, 16'h0000);
    run(7, irqs);
    rd(2'd1, v); chk("R4 clear on count write", v, 16'd0);
    run(1, irqs);
    rd(2'd1, v); chk("R4 advance after 8 ticks", v, 16'd1);
    run(3, irqs);
    wr(2'd0, 16'h8010);
    run(7, irqs);
    rd(2'd1, v); chk("R4 clear on ctrl write", v, 16'd1);

    // R5 stop in idle, timer mode
    setup(16'hA000, 16'hFFFF);
    cpu_idle_i = 1'b1;
    rd(2'd1, a); run(10, irqs); rd(2'd1, b);
    chk("R5 idle stop bit 1", b - a, 16'd0);
    wr(2'd0, 16'h8000);
    rd(2'd1, a); run(10, irqs); rd(2'd1, b);
    chk("R5 idle stop bit 0", b - a, 16'd10);
    cpu_idle_i = 1'b0;

    // R6 sleep freezes timer mode
    cpu_sleep_i = 1'b1;
    rd(2'd1, a); run(10, irqs); rd(2'd1, b);
    chk("R6 timer sleep", b - a, 16'd0);
    cpu_sleep_i = 1'b0;

    // R7 synchronous counter
    setup(16'h8006, 16'hFFFF);
    repeat (4) @(negedge clk_i);
    rd(2'd1, a); ext_pulses(6); rd(2'd1, b);
    chk("R7 sync edges", b - a, 16'd6);
    wr(2'd0, 16'hA006);
    cpu_idle_i = 1'b1;
    rd(2'd1, a); ext_pulses(4); rd(2'd1, b);
    chk("R5 sync idle stop", b - a, 16'd0);
    cpu_idle_i = 1'b0;
    cpu_sleep_i = 1'b1;
    rd(2'd1, a); ext_pulses(4); rd(2'd1, b);
    chk("R6 sync sleep", b - a, 16'd0);
    cpu_sleep_i = 1'b0;

    // R8 asynchronous counter runs in idle and sleep
    setup(16'hA002, 16'hFFFF);
    cpu_idle_i = 1'b1; cpu_sleep_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(2'd1, a); ext_pulses(5); rd(2'd1, b);
    chk("R8 async idle sleep", b - a, 16'd5);
    cpu_idle_i = 1'b0; cpu_sleep_i = 1'b0;

    // R9 gated accumulation, R10 gate falling edge
    setup(16'h8040, 16'hFFFF);
    gate_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rd(2'd1, a); run(10, irqs); rd(2'd1, b);
    chk("R9 gate low", b - a, 16'd0);
    gate_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(2'd1, a); run(10, irqs); rd(2'd1, b);
    chk("R9 gate high", b - a, 16'd10);
    gate_i = 1'b0;
    run(8, irqs);
    chk("R10 gate fall irq", 16'(irqs), 16'd1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule